// File: doc/BRIEF.md
# RTC Event Status and Interrupt Controller

This block gathers the event strobes of a real-time clock into one 16-bit status register and gates them through a 16-bit control mask onto a single interrupt request line. The timekeeper next to it supplies second, minute, hour and day-rollover strobes, a stopwatch expiry strobe and the alarm comparison results. The slow once-per-second tick is also used to commit control-mask writes. A simple register port lets software read both registers, clear status bits by writing ones, and request a new control mask.

Status bits latch whenever their event occurs, whether or not they are enabled. Clears of status take effect on the next clock. A control-mask write is held in a shadow register until the next tick. While it waits, a live pending flag shows in the status register. At the tick the mask is committed and a completion bit latches. A second control write made while one is still waiting is dropped.

Top module: `rtc_evt_irq_ctrl`

## Requirements
- R1: After reset the status reads 0x0000, the control mask reads 0x0000 and irq is low.
- R2: A one-cycle pulse on secEvt, minEvt, hourEvt, dayEvt or swEvt sets status bit 2, 3, 4, 5 or 0 respectively on the next clock, whatever the control mask holds.
- R3: A cycle with todMatch high sets status bit 1. When dayMatch is also high in that cycle, status bit 6 is set as well. todMatch alone leaves bit 6 clear, and dayMatch alone sets nothing.
- R4: A write with regSel=0 clears every status bit whose regWdata bit is 1, visible on the next clock, and leaves the other bits unchanged.
- R5: An event arriving in the same cycle as a status write that clears its bit leaves that bit set.
- R6: A write with regSel=1 and no write pending leaves the control mask unchanged and sets status bit 14 on the next clock. At the first later cycle with tick high, the mask takes the written value, bit 14 drops and status bit 15 sets. A tick with nothing pending changes nothing.
- R7: A control write issued while status bit 14 is high is discarded.
- R8: irq is high exactly when some bit among 15 and 6..0 is set in both status and control. Control bits 14 and 13..7 never raise irq, and irq falls once the enabled status bits are cleared.
- R9: Status bit 14 is read-only and cannot be cleared by a status write. Status bits 13..7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe per RTC second, commits pending control writes |
| secEvt | input | 1 | Second boundary strobe |
| minEvt | input | 1 | Minute rollover strobe |
| hourEvt | input | 1 | Hour rollover strobe |
| dayEvt | input | 1 | 24-hour rollover strobe |
| swEvt | input | 1 | Stopwatch expiry strobe |
| todMatch | input | 1 | Time of day equals the alarm time |
| dayMatch | input | 1 | Day count equals the alarm day |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects status, 1 selects control |
| regWdata | input | 16 | Register write data |
| statusOut | output | 16 | Status register read value |
| ctrlOut | output | 16 | Committed control mask |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions need targeting. The first is an event strobe in the same clock as a write-one-to-clear of its own bit. The bench drives secEvt together with a status write of bit 2, and also clears a neighbouring bit in that write. It expects bit 2 to stay set with irq high and the neighbour to clear. The second is a control write that lands while an earlier one still waits for the tick. The bench issues a second mask between request and tick, then checks that the committed mask equals the first one.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int REG_W = 16;

  // Bit positions shared by status and control
  localparam int B_WDONE  = 15;
  localparam int B_WPEND  = 14;
  localparam int B_ALMDAY = 6;
  localparam int B_DAY    = 5;
  localparam int B_HOUR   = 4;
  localparam int B_MIN    = 3;
  localparam int B_SEC    = 2;
  localparam int B_ALM    = 1;
  localparam int B_SW     = 0;

  // Bits that hold latched status and may raise the request line
  localparam logic [REG_W-1:0] LATCH_MASK = 16'h807F;

  typedef struct packed {
    logic captureShadow;
    logic commitCtrl;
  } wr_strobe_t;
endpackage

// File: rtl/rtc_evt_wrsync.sv
module rtc_evt_wrsync
  import rtc_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       ctrlWrReq,
  output logic       pending,
  output wr_strobe_t strb
);
  logic pendingQ;

  always_comb begin
    strb.captureShadow = ctrlWrReq & ~pendingQ;
    strb.commitCtrl    = pendingQ & tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingQ <= 1'b0;
    else if (strb.captureShadow) pendingQ <= 1'b1;
    else if (strb.commitCtrl) pendingQ <= 1'b0;
  end

  assign pending = pendingQ;
endmodule

// File: rtl/rtc_evt_datapath.sv
module rtc_evt_datapath
  import rtc_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wr_strobe_t       strb,
  input  logic [REG_W-1:0] setVec,
  input  logic [REG_W-1:0] clrVec,
  input  logic [REG_W-1:0] ctrlWdata,
  output logic [REG_W-1:0] statusQ,
  output logic [REG_W-1:0] ctrlQ
);
  logic [REG_W-1:0] shadowQ;

  for (genvar i = 0; i < REG_W; i++) begin : g_stat
    if (LATCH_MASK[i]) begin : g_flop
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) statusQ[i] <= 1'b0;
        else statusQ[i] <= setVec[i] | (statusQ[i] & ~clrVec[i]);
      end
    end else begin : g_zero
      assign statusQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
      ctrlQ   <= '0;
    end else begin
      if (strb.captureShadow) shadowQ <= ctrlWdata;
      if (strb.commitCtrl) ctrlQ <= shadowQ;
    end
  end
endmodule

// File: rtl/rtc_evt_irq_ctrl.sv
module rtc_evt_irq_ctrl
  import rtc_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             secEvt,
  input  logic             minEvt,
  input  logic             hourEvt,
  input  logic             dayEvt,
  input  logic             swEvt,
  input  logic             todMatch,
  input  logic             dayMatch,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] statusOut,
  output logic [REG_W-1:0] ctrlOut,
  output logic             irq
);
  wr_strobe_t       strb;
  logic             pending;
  logic [REG_W-1:0] setVec;
  logic [REG_W-1:0] clrVec;
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] ctrlQ;

  always_comb begin
    setVec           = '0;
    setVec[B_WDONE]  = strb.commitCtrl;
    setVec[B_ALMDAY] = todMatch & dayMatch;
    setVec[B_DAY]    = dayEvt;
    setVec[B_HOUR]   = hourEvt;
    setVec[B_MIN]    = minEvt;
    setVec[B_SEC]    = secEvt;
    setVec[B_ALM]    = todMatch;
    setVec[B_SW]     = swEvt;
    clrVec = (regWrEn && !regSel) ? regWdata : '0;
  end

  rtc_evt_wrsync u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .ctrlWrReq (regWrEn & regSel),
    .pending   (pending),
    .strb      (strb)
  );

  rtc_evt_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .setVec    (setVec),
    .clrVec    (clrVec),
    .ctrlWdata (regWdata),
    .statusQ   (statusQ),
    .ctrlQ     (ctrlQ)
  );

  always_comb begin
    statusOut          = statusQ;
    statusOut[B_WPEND] = pending;
  end

  assign ctrlOut = ctrlQ;
  assign irq     = |(statusQ & ctrlQ & LATCH_MASK);
endmodule

// File: rtl/rtc_evt_irq_chk.sv
module rtc_evt_irq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        tick,
  input logic        secEvt,
  input logic        minEvt,
  input logic        hourEvt,
  input logic        dayEvt,
  input logic        swEvt,
  input logic        todMatch,
  input logic        dayMatch,
  input logic        regWrEn,
  input logic        regSel,
  input logic [15:0] regWdata,
  input logic [15:0] statusOut,
  input logic [15:0] ctrlOut,
  input logic        irq
);
  assert_sec_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    secEvt |=> statusOut[2]);

  assert_sw_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    swEvt |=> statusOut[0]);

  assert_alarm_day_R3: assert property (@(posedge clk) disable iff (!rstN)
    (todMatch && dayMatch) |=> (statusOut[6] && statusOut[1]));

  assert_alarm_noday_R3: assert property (@(posedge clk) disable iff (!rstN)
    (todMatch && !dayMatch && !statusOut[6]) |=> !statusOut[6]);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && regWdata[3] && !minEvt) |=> !statusOut[3]);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && regWdata[2] && secEvt) |=> statusOut[2]);

  assert_deferred_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel && !statusOut[14]) |=> (statusOut[14] && $stable(ctrlOut)));

  assert_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[14] && tick) |=> (!statusOut[14] && statusOut[15]));

  assert_lost_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[14] && !tick) |=> $stable(ctrlOut));

  assert_no_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut == 16'h0000) |-> !irq);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[13:7] == 7'd0);
endmodule

bind rtc_evt_irq_ctrl rtc_evt_irq_chk u_chk (.*);

// File: tb/sim_rtc_evt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_rtc_evt_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 0, secEvt = 0, minEvt = 0, hourEvt = 0, dayEvt = 0, swEvt = 0;
  logic        todMatch = 0, dayMatch = 0, regWrEn = 0, regSel = 0;
  logic [15:0] regWdata = '0;
  logic [15:0] statusOut, ctrlOut;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  rtc_evt_irq_ctrl u0 (.*);

  task automatic cycle();
    @(posedge clk);
    #1;
    {tick, secEvt, minEvt, hourEvt, dayEvt, swEvt, todMatch, dayMatch, regWrEn, regSel} = '0;
    regWdata = '0;
  endtask

  task automatic chk(string req, logic [15:0] st, logic [15:0] ct, logic iq);
    checks++;
    if (statusOut !== st || ctrlOut !== ct || irq !== iq) begin
      errors++;
      $display("FAIL %s: status=%h ctrl=%h irq=%b expected status=%h ctrl=%h irq=%b",
               req, statusOut, ctrlOut, irq, st, ct, iq);
    end
  endtask

  task automatic wrStatus(logic [15:0] d);
    regWrEn = 1; regSel = 0; regWdata = d; cycle();
  endtask

  task automatic wrCtrl(logic [15:0] d);
    regWrEn = 1; regSel = 1; regWdata = d; cycle();
  endtask

  task automatic pulseTick();
    tick = 1; cycle();
  endtask

  task automatic t_reset();
    chk("R1", 16'h0000, 16'h0000, 1'b0);
  endtask

  task automatic t_latch();
    secEvt = 1; cycle();
    chk("R2", 16'h0004, 16'h0000, 1'b0);
    minEvt = 1; hourEvt = 1; cycle();
    dayEvt = 1; swEvt = 1; cycle();
    chk("R2", 16'h003D, 16'h0000, 1'b0);
    wrStatus(16'h0030);
    chk("R4", 16'h000D, 16'h0000, 1'b0);
    wrStatus(16'hFFFF);
    chk("R4", 16'h0000, 16'h0000, 1'b0);
  endtask

  task automatic t_alarm();
    todMatch = 1; cycle();
    chk("R3", 16'h0002, 16'h0000, 1'b0);
    wrStatus(16'h0002);
    dayMatch = 1; cycle();
    chk("R3", 16'h0000, 16'h0000, 1'b0);
    todMatch = 1; dayMatch = 1; cycle();
    chk("R3", 16'h0042, 16'h0000, 1'b0);
    wrStatus(16'h0042);
  endtask

  task automatic t_ctrl();
    pulseTick();
    chk("R6", 16'h0000, 16'h0000, 1'b0);
    wrCtrl(16'h0004);
    chk("R6", 16'h4000, 16'h0000, 1'b0);
    cycle(); cycle();
    chk("R6", 16'h4000, 16'h0000, 1'b0);
    pulseTick();
    chk("R6", 16'h8000, 16'h0004, 1'b0);
    wrStatus(16'h8000);
    wrCtrl(16'h8006);
    wrCtrl(16'h0001);
    chk("R7", 16'h4000, 16'h0004, 1'b0);
    pulseTick();
    chk("R7", 16'h8000, 16'h8006, 1'b1);
    wrStatus(16'h8000);
    chk("R8", 16'h0000, 16'h8006, 1'b0);
  endtask

  task automatic t_irq();
    secEvt = 1; cycle();
    chk("R8", 16'h0004, 16'h8006, 1'b1);
    wrStatus(16'h0004);
    chk("R8", 16'h0000, 16'h8006, 1'b0);
    swEvt = 1; cycle();
    chk("R8", 16'h0001, 16'h8006, 1'b0);
    wrStatus(16'h0001);
  endtask

  task automatic t_same();
    minEvt = 1; cycle();
    secEvt = 1; regWrEn = 1; regSel = 0; regWdata = 16'h000C; cycle();
    chk("R5", 16'h0004, 16'h8006, 1'b1);
    wrStatus(16'h0004);
    chk("R5", 16'h0000, 16'h8006, 1'b0);
  endtask

  task automatic t_readonly();
    wrCtrl(16'hFFFF);
    wrStatus(16'h4000);
    chk("R9", 16'h4000, 16'h8006, 1'b0);
    pulseTick();
    chk("R9", 16'h8000, 16'hFFFF, 1'b1);
    wrStatus(16'h8000);
    chk("R8", 16'h0000, 16'hFFFF, 1'b0);
    secEvt = 1; minEvt = 1; hourEvt = 1; dayEvt = 1; swEvt = 1;
    todMatch = 1; dayMatch = 1; cycle();
    chk("R9", 16'h007F, 16'hFFFF, 1'b1);
    wrStatus(16'hFFFF);
    chk("R8", 16'h0000, 16'hFFFF, 1'b0);
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_latch();
    t_alarm();
    t_ctrl();
    t_irq();
    t_same();
    t_readonly();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule